// File: doc/BRIEF.md
# Serial Character Transmitter with Programmable Bit Rate

This block turns parallel bytes into asynchronous serial characters on a single output line. When nothing is being sent the line is held high. A byte offered on a valid/ready handshake is sent as a character: one low start bit, then the eight data bits with the least significant bit first, then one or two high stop bits.

The bit rate comes from the system clock through a programmable divider. A 12-bit divider value X makes a prescaler that gives one sample tick every X+1 clocks. A bit lasts 16 ticks in normal mode and 8 ticks when the double-speed input is set. The bit rate is therefore Fclk/(16(X+1)) or Fclk/(8(X+1)). The divider value, the speed selection and the stop-bit count are captured when a byte is accepted. They stay fixed for the whole character.

Top module: `uart_tx`

## Requirements
- R1: After reset, and whenever no character is in progress, `tx_o` is high, `ready_o` is high and `busy_o` is low.
- R2: A byte is accepted on a rising clock edge where `valid_i` and `ready_o` are both high. `tx_o` goes low (the start bit) at that same edge.
- R3: The eight data bits follow the start bit with bit 0 first and bit 7 last. Each data bit is driven on `tx_o` for exactly one bit time.
- R4: With `two_stop_i` low at acceptance the character ends with one high stop bit. With it high the character ends with two high stop bits.
- R5: With `dbl_speed_i` low at acceptance one bit time is exactly 16*(X+1) clock cycles, where X is `div_i` at acceptance.
- R6: With `dbl_speed_i` high at acceptance one bit time is exactly 8*(X+1) clock cycles.
- R7: A character with one stop bit lasts 10 bit times from acceptance to the return of `ready_o`. A character with two stop bits lasts 11 bit times.
- R8: `ready_o` is low and `busy_o` is high from the accepting edge until the edge that ends the last stop bit. `valid_i` and `data_i` have no effect during that time.
- R9: Changes to `div_i`, `dbl_speed_i` or `two_stop_i` while a character is in progress do not change its timing or its stop-bit count. They apply from the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 12 | Divider value X; one sample tick per X+1 clocks |
| dbl_speed_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| two_stop_i | input | 1 | 1: two stop bits, 0: one stop bit |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte on `data_i` is offered |
| ready_o | output | 1 | Transmitter idle and able to accept a byte |
| busy_o | output | 1 | Character in progress |
| tx_o | output | 1 | Serial line output |

## Verification
The hardest case to reach is a character whose settings change while it is being sent. The frame must keep the divider, speed and stop count it latched at acceptance, even though the live inputs now ask for something else. To reach it, the bench accepts a byte and then, on the next cycle, changes all three settings and offers a different byte with `valid_i` held high. It then checks the level of every bit in that character at the first and last cycle of its original bit time. This shows both that the old timing is kept and that the second byte was not taken.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DIV_W  = 12;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OSR    = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned OSR   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             active_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             dbl_i,
  output logic             bit_end_o
);
  localparam int unsigned SMP_W = $clog2(OSR);
  localparam logic [SMP_W-1:0] LAST_N = SMP_W'(OSR - 1);
  localparam logic [SMP_W-1:0] LAST_D = SMP_W'(OSR / 2 - 1);

  logic [DIV_W-1:0] div_q, cnt_q;
  logic [SMP_W-1:0] smp_q, last_q;
  logic             tick;

  assign tick      = active_i && (cnt_q == '0);
  assign bit_end_o = tick && (smp_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      cnt_q  <= '0;
      smp_q  <= '0;
      last_q <= LAST_N;
    end else if (start_i) begin
      // settings frozen for the whole frame
      div_q  <= div_i;
      cnt_q  <= div_i;
      smp_q  <= '0;
      last_q <= dbl_i ? LAST_D : LAST_N;
    end else if (active_i) begin
      if (tick) begin
        cnt_q <= div_q;
        smp_q <= (smp_q == last_q) ? '0 : smp_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              two_stop_i,
  input  logic              bit_end_i,
  output logic              accept_o,
  output logic              active_o,
  output logic              tx_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              two_q, second_q, tx_q;

  assign accept_o = valid_i && (state_q == ST_IDLE);
  assign active_o = (state_q != ST_IDLE);
  assign tx_o     = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      two_q     <= 1'b0;
      second_q  <= 1'b0;
      tx_q      <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          tx_q <= 1'b1;
          if (accept_o) begin
            state_q  <= ST_START;
            shreg_q  <= data_i;
            two_q    <= two_stop_i;
            second_q <= 1'b0;
            tx_q     <= 1'b0;
          end
        end
        ST_START: if (bit_end_i) begin
          state_q   <= ST_DATA;
          bit_cnt_q <= '0;
          tx_q      <= shreg_q[0];
          shreg_q   <= shreg_q >> 1;
        end
        ST_DATA: if (bit_end_i) begin
          if (bit_cnt_q == LAST_BIT) begin
            state_q <= ST_STOP;
            tx_q    <= 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            tx_q      <= shreg_q[0];
            shreg_q   <= shreg_q >> 1;
          end
        end
        ST_STOP: if (bit_end_i) begin
          if (two_q && !second_q) second_q <= 1'b1;
          else                    state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              dbl_speed_i,
  input  logic              two_stop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              tx_o
);
  logic accept, active, bit_end;

  uart_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .data_i     (data_i),
    .two_stop_i (two_stop_i),
    .bit_end_i  (bit_end),
    .accept_o   (accept),
    .active_o   (active),
    .tx_o       (tx_o)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .OSR(OSR)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .active_i  (active),
    .div_i     (div_i),
    .dbl_i     (dbl_speed_i),
    .bit_end_o (bit_end)
  );

  assign ready_o = !active;
  assign busy_o  = active;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic busy_o,
  input logic tx_o,
  input logic bit_end
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> tx_o);

  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (!tx_o && busy_o));

  // R8
  ready_falls_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(valid_i));

  // R3
  tx_moves_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_o != $past(tx_o)) |-> ($past(bit_end) || $past(valid_i && ready_o)));

  // R4
  ends_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (tx_o && $past(tx_o)));

  // R8
  no_tick_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !bit_end);
endmodule

bind uart_tx uart_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .busy_o  (busy_o),
  .tx_o    (tx_o),
  .bit_end (bit_end)
);

// File: tb/uart_tx_test.sv
module uart_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div = '0;
  logic        dbl = 1'b0;
  logic        two = 1'b0;
  logic [7:0]  data = '0;
  logic        valid = 1'b0;
  logic        ready, busy, tx;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .dbl_speed_i(dbl),
    .two_stop_i(two), .data_i(data), .valid_i(valid),
    .ready_o(ready), .busy_o(busy), .tx_o(tx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Sends one byte and checks each bit at its first and last cycle.
  task automatic run_frame(input logic [7:0] b, input int x, input bit d,
                           input bit t, input bit disturb);
    int bt = (d ? 8 : 16) * (x + 1);
    int nb = t ? 11 : 10;
    check(ready === 1'b1, "R8 ready before send", int'(ready), 1);
    div = 12'(x); dbl = d; two = t; data = b; valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    if (disturb) begin
      // R9 and R8: new settings and a foreign byte during the frame
      div = 12'(x + 3); dbl = !d; two = !t; data = ~b; valid = 1'b1;
    end
    for (int k = 0; k < nb; k++) begin
      logic exp;
      if (k == 0) exp = 1'b0;
      else if (k <= 8) exp = b[k-1];
      else exp = 1'b1;
      check(tx === exp, k == 0 ? "R2 start bit" : (k <= 8 ? "R3 data bit" : "R4 stop bit"),
            int'(tx), int'(exp));
      check(ready === 1'b0 && busy === 1'b1, "R8 busy in frame", int'(ready), 0);
      repeat (bt - 1) @(negedge clk);
      check(tx === exp, d ? "R6 bit length" : "R5 bit length", int'(tx), int'(exp));
      if (disturb) check(tx === exp, "R9 settings held", int'(tx), int'(exp));
      if (k == nb - 1) valid = 1'b0;
      @(negedge clk);
    end
    check(ready === 1'b1 && busy === 1'b0, "R7 frame length", int'(ready), 1);
    check(tx === 1'b1, "R1 idle high", int'(tx), 1);
    @(negedge clk);
    check(ready === 1'b1 && tx === 1'b1, "R8 foreign byte not taken", int'(tx), 1);
  endtask

  task automatic test_reset;
    check(tx === 1'b1, "R1 reset tx", int'(tx), 1);
    check(ready === 1'b1, "R1 reset ready", int'(ready), 1);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
  endtask

  task automatic test_idle_hold;
    repeat (20) @(negedge clk);
    check(tx === 1'b1 && ready === 1'b1, "R1 idle hold", int'(tx), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_idle_hold();
    run_frame(8'h41, 0, 1'b0, 1'b0, 1'b0); // R5, R7 with X=0
    run_frame(8'hA5, 1, 1'b0, 1'b1, 1'b0); // R4 two stops
    run_frame(8'h3C, 2, 1'b1, 1'b0, 1'b0); // R6 double speed
    run_frame(8'h01, 0, 1'b1, 1'b1, 1'b0);
    run_frame(8'h80, 1, 1'b0, 1'b0, 1'b1); // R9 disturbed
    run_frame(8'hFF, 0, 1'b1, 1'b1, 1'b1);
    run_frame(8'h00, 2, 1'b0, 1'b0, 1'b0);
    test_idle_hold();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule